// File: doc/BRIEF.md
# Two-Port Memory with Atomic Conditional Update

This block is a small synchronous word memory with two independent access ports. Either port can read or write any word. Either port can also start an atomic conditional update. The requester supplies an address, a replacement value, a comparison operand and a condition code. The memory fetches the current word and evaluates the condition on it. It stores the replacement only when the condition holds. It then returns the prior word and a pass flag.

While one port's update is in progress, the target word is reserved. The other port cannot change that word: a modifying request to it is answered with a busy response, and that port is expected to retry. Reads of the reserved word return the value it held before the update. The block supports two ways of guarding the word, chosen by a parameter. The default mode compares the address against a reservation register. The sentinel mode parks a marker value in the word while the update is pending, and an update request that finds the marker is refused.

A one-word lock is built from this block as follows. The condition is "word is zero" and the replacement is 1. A prior value of 0 means the lock was taken. Releasing the lock is a plain write of 0.

Top module: `tas_dpram`

## Requirements
- R1: A read (op code 01) returns the stored word on `x_rsp_data`, with `x_rsp_valid` high, in the cycle after the request. A write (op code 10) is acknowledged the same way, and a later read from either port returns the written word.
- R2: An update (op code 11) drives `x_ready` low in the cycle after issue, and requests seen while `x_ready` is low have no effect. The response (`x_rsp_valid` high, prior word on `x_rsp_data`) arrives two cycles after issue.
- R3: The 2-bit condition code is 00 = always, 01 = prior word equals `x_cmp`, 10 = prior word is zero, 11 = prior word is nonzero. `x_rsp_pass` reports whether the condition held.
- R4: When the condition holds, the word becomes `x_wdata`. When it fails, the word keeps its prior value.
- R5: An update from the other port to a word that is under update is answered with `x_rsp_busy` high in the next cycle, and it does not change the word.
- R6: A write from the other port to a word that is under update is answered with busy and is dropped.
- R7: A read of a word that is under update returns the value from before the update.
- R8: When both ports issue a write or an update to the same address in the same cycle, port A proceeds and port B gets busy.
- R9: Updates to different addresses issued on both ports in the same cycle both complete in the same cycle.
- R10: After an update completes, a retried update from the other port to the same word proceeds normally.
- R11: In sentinel mode, the port behaviour is the same as in the default mode, except that an update which finds the marker value stored in the word is answered with busy.
- R12: Lock use works as follows. An update with condition 10 and value 1 on a free word returns 0 and passes. A second attempt returns 1 and fails. After a write of 0, a new attempt succeeds.
- R13: After reset, every word reads 0, both `x_ready` are high, and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_req | input | 1 | Port A request strobe |
| a_op | input | 2 | Port A operation: 00 none, 01 read, 10 write, 11 update |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write or replacement value |
| a_cmp | input | DATA_W | Port A comparison operand |
| a_test | input | 2 | Port A condition code |
| a_ready | output | 1 | Port A accepts a request this cycle |
| a_rsp_valid | output | 1 | Port A response valid |
| a_rsp_busy | output | 1 | Port A request refused, retry |
| a_rsp_pass | output | 1 | Port A update condition held |
| a_rsp_data | output | DATA_W | Port A read data or prior word |
| b_req | input | 1 | Port B request strobe |
| b_op | input | 2 | Port B operation |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write or replacement value |
| b_cmp | input | DATA_W | Port B comparison operand |
| b_test | input | 2 | Port B condition code |
| b_ready | output | 1 | Port B accepts a request this cycle |
| b_rsp_valid | output | 1 | Port B response valid |
| b_rsp_busy | output | 1 | Port B request refused, retry |
| b_rsp_pass | output | 1 | Port B update condition held |
| b_rsp_data | output | DATA_W | Port B read data or prior word |

## Verification
The hardest case to reach is a collision with a reservation, because that reservation lives for only one cycle. The stimulus waits exactly one falling edge after port A issues an update, then places port B's update, write or read on the same address. This lands B's request in A's evaluate cycle. The bench then checks the busy and pre-update responses, reads the word back, and retries from B. The same stimulus runs against both guard modes at once, plus one case with the marker value stored, where the two modes must answer differently.

// File: rtl/tas_pkg.sv
// Shared encodings for the two-port conditional-update memory.
// Assumes op and condition fields are 2 bits wide on every port.
package tas_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_TAS   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        TST_ALWAYS  = 2'b00,
        TST_EQUAL   = 2'b01,
        TST_ZERO    = 2'b10,
        TST_NONZERO = 2'b11
    } test_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } port_state_e;
endpackage

// File: rtl/tas_mem.sv
// Word storage with two combinational read ports and two write ports.
// Assumes the callers never write the same address in one cycle.
module tas_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    we,
    input  logic [1:0][ADDR_W-1:0]        waddr,
    input  logic [1:0][DATA_W-1:0]        wdata,
    input  logic [1:0][ADDR_W-1:0]        raddr,
    output logic [1:0][DATA_W-1:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    // Clear on reset, otherwise apply each port's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (we[p]) words_q[waddr[p]] <= wdata[p];
            end
        end
    end

    // Combinational read for each port.
    always_comb begin
        for (int p = 0; p < 2; p++) rdata[p] = words_q[raddr[p]];
    end

    AST_WRITE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (we[0] && we[1]) |-> (waddr[0] != waddr[1])) else $error("dual write to one word"); // R6
endmodule

// File: rtl/tas_conflict.sv
// Decides which port requests are refused with busy. Modifying requests
// that hit the other port's reservation are refused. In sentinel mode an
// update is refused when it reads the marker word. On a same-cycle
// modifying tie, port B loses.
module tas_conflict #(
    parameter int              DATA_W    = 8,
    parameter int              ADDR_W    = 4,
    parameter bit              SENTINEL  = 1'b0,
    parameter logic [DATA_W-1:0] FLAG_WORD = '1
) (
    input  logic [1:0]                 mod_issue,
    input  logic [1:0]                 tas_issue,
    input  logic [1:0][ADDR_W-1:0]     addr,
    input  logic [1:0][DATA_W-1:0]     rd_word,
    input  logic [1:0]                 rsv_valid,
    input  logic [1:0][ADDR_W-1:0]     rsv_addr,
    output logic [1:0]                 busy
);
    logic [1:0] rsv_hit;
    logic [1:0] tas_block;
    logic [1:0] wr_block;
    logic       tie;

    for (genvar g = 0; g < 2; g++) begin : g_port
        localparam int OTHER = 1 - g;
        // Does this port's address fall on the other port's reservation.
        assign rsv_hit[g] = rsv_valid[OTHER] && (rsv_addr[OTHER] == addr[g]);
        if (SENTINEL) begin : g_sentinel
            // Update refused when the word already carries the marker.
            assign tas_block[g] = tas_issue[g] && (rd_word[g] == FLAG_WORD);
        end else begin : g_reserve
            // Update refused when the address is reserved.
            assign tas_block[g] = tas_issue[g] && rsv_hit[g];
        end
        // Plain write refused on a reserved address.
        assign wr_block[g] = mod_issue[g] && !tas_issue[g] && rsv_hit[g];
    end

    // Same-cycle modifying requests to one address: A wins.
    assign tie = mod_issue[0] && mod_issue[1] && (addr[0] == addr[1]);

    // Combine refusal causes per port.
    always_comb begin
        busy[0] = tas_block[0] || wr_block[0];
        busy[1] = tas_block[1] || wr_block[1] || tie;
    end
endmodule

// File: rtl/tas_port_ctrl.sv
// Per-port sequencer. Reads and writes complete in one cycle. An update
// takes a reserve cycle (capture prior word) and an evaluate cycle
// (conditional write), and the response appears one cycle later.
// Assumes busy_i is resolved combinationally in the issue cycle.
module tas_port_ctrl
    import tas_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 4,
    parameter bit                SENTINEL  = 1'b0,
    parameter logic [DATA_W-1:0] FLAG_WORD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] cmp_i,
    input  logic [1:0]        test_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_word_i,
    input  logic              fwd_hit_i,
    input  logic [DATA_W-1:0] fwd_word_i,
    output logic              ready_o,
    output logic              mod_issue_o,
    output logic              tas_issue_o,
    output logic              rsv_valid_o,
    output logic [ADDR_W-1:0] rsv_addr_o,
    output logic [DATA_W-1:0] held_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rsp_valid_o,
    output logic              rsp_busy_o,
    output logic              rsp_pass_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    port_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] cmp_q;
    test_e             test_q;
    op_e               op;
    logic              accept;
    logic              pass_w;

    // Condition evaluation on the captured prior word.
    function automatic logic cond_holds(test_e t, logic [DATA_W-1:0] w, logic [DATA_W-1:0] c);
        case (t)
            TST_ALWAYS:  return 1'b1;
            TST_EQUAL:   return w == c;
            TST_ZERO:    return w == '0;
            default:     return w != '0;
        endcase
    endfunction

    // Decode the request and its acceptance.
    always_comb begin
        op          = op_e'(op_i);
        ready_o     = (state_q == ST_IDLE);
        accept      = req_i && ready_o && (op != OP_NONE);
        mod_issue_o = req_i && ready_o && (op == OP_WRITE || op == OP_TAS);
        tas_issue_o = req_i && ready_o && (op == OP_TAS);
        pass_w      = cond_holds(test_q, old_q, cmp_q);
        rsv_valid_o = (state_q == ST_EVAL);
        rsv_addr_o  = addr_q;
        held_o      = old_q;
    end

    // Memory write request: conditional store, plain write or marker park.
    always_comb begin
        we_o    = 1'b0;
        waddr_o = addr_i;
        wdata_o = wdata_i;
        if (state_q == ST_EVAL) begin
            waddr_o = addr_q;
            wdata_o = pass_w ? val_q : old_q;
            we_o    = SENTINEL ? 1'b1 : pass_w;
        end else if (accept && !busy_i) begin
            if (op == OP_WRITE) begin
                we_o = 1'b1;
            end else if (op == OP_TAS && SENTINEL) begin
                we_o    = 1'b1;
                wdata_o = FLAG_WORD;
            end
        end
    end

    // Sequencer state, captured operands and registered responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            old_q       <= '0;
            val_q       <= '0;
            cmp_q       <= '0;
            test_q      <= TST_ALWAYS;
            rsp_valid_o <= 1'b0;
            rsp_busy_o  <= 1'b0;
            rsp_pass_o  <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= 1'b0;
            rsp_busy_o  <= 1'b0;
            rsp_pass_o  <= 1'b0;
            if (state_q == ST_EVAL) begin
                rsp_valid_o <= 1'b1;
                rsp_pass_o  <= pass_w;
                rsp_data_o  <= old_q;
                state_q     <= ST_IDLE;
            end else if (accept) begin
                rsp_data_o <= '0;
                if (busy_i) begin
                    rsp_valid_o <= 1'b1;
                    rsp_busy_o  <= 1'b1;
                end else begin
                    case (op)
                        OP_READ: begin
                            rsp_valid_o <= 1'b1;
                            rsp_data_o  <= fwd_hit_i ? fwd_word_i : rd_word_i;
                        end
                        OP_WRITE: rsp_valid_o <= 1'b1;
                        default: begin
                            state_q <= ST_EVAL;
                            addr_q  <= addr_i;
                            old_q   <= rd_word_i;
                            val_q   <= wdata_i;
                            cmp_q   <= cmp_i;
                            test_q  <= test_e'(test_i);
                        end
                    endcase
                end
            end
        end
    end

    AST_RSP_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid_o |=> (rsp_valid_o && !rsp_busy_o)) else $error("update response missing"); // R2
    AST_RESERVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid_o |=> !rsv_valid_o) else $error("reservation held too long"); // R10
    AST_RESERVE_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsv_valid_o) |-> $past(tas_issue_o && !busy_i)) else $error("reservation without issue"); // R2
endmodule

// File: rtl/tas_dpram.sv
// Top of the two-port memory with atomic conditional update. Wires two
// port sequencers to shared storage and the busy arbiter.
// Assumes requests are held only for the cycle they are presented.
module tas_dpram #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 4,
    parameter bit                SENTINEL  = 1'b0,
    parameter logic [DATA_W-1:0] FLAG_WORD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic [1:0]        a_op,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [DATA_W-1:0] a_cmp,
    input  logic [1:0]        a_test,
    output logic              a_ready,
    output logic              a_rsp_valid,
    output logic              a_rsp_busy,
    output logic              a_rsp_pass,
    output logic [DATA_W-1:0] a_rsp_data,
    input  logic              b_req,
    input  logic [1:0]        b_op,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [DATA_W-1:0] b_cmp,
    input  logic [1:0]        b_test,
    output logic              b_ready,
    output logic              b_rsp_valid,
    output logic              b_rsp_busy,
    output logic              b_rsp_pass,
    output logic [DATA_W-1:0] b_rsp_data
);
    logic [1:0]              req, ready, mod_issue, tas_issue, busy;
    logic [1:0]              rsv_valid, we, fwd_hit;
    logic [1:0]              rsp_valid, rsp_busy, rsp_pass;
    logic [1:0][1:0]         op, test;
    logic [1:0][ADDR_W-1:0]  addr, rsv_addr, waddr;
    logic [1:0][DATA_W-1:0]  wdata, cmp, rd_word, held, mem_wdata, rsp_data;

    // Gather port pins into indexed form.
    always_comb begin
        req   = {b_req, a_req};
        op    = {b_op, a_op};
        addr  = {b_addr, a_addr};
        wdata = {b_wdata, a_wdata};
        cmp   = {b_cmp, a_cmp};
        test  = {b_test, a_test};
    end

    // Scatter indexed results back to port pins.
    always_comb begin
        {b_ready, a_ready}         = ready;
        {b_rsp_valid, a_rsp_valid} = rsp_valid;
        {b_rsp_busy, a_rsp_busy}   = rsp_busy;
        {b_rsp_pass, a_rsp_pass}   = rsp_pass;
        a_rsp_data                 = rsp_data[0];
        b_rsp_data                 = rsp_data[1];
    end

    for (genvar g = 0; g < 2; g++) begin : g_port
        localparam int OTHER = 1 - g;
        // Reads of the other port's reserved word see its held prior value.
        assign fwd_hit[g] = rsv_valid[OTHER] && (rsv_addr[OTHER] == addr[g]);

        tas_port_ctrl #(
            .DATA_W(DATA_W), .ADDR_W(ADDR_W),
            .SENTINEL(SENTINEL), .FLAG_WORD(FLAG_WORD)
        ) u_ctrl (
            .clk(clk), .rst_n(rst_n),
            .req_i(req[g]), .op_i(op[g]), .addr_i(addr[g]),
            .wdata_i(wdata[g]), .cmp_i(cmp[g]), .test_i(test[g]),
            .busy_i(busy[g]), .rd_word_i(rd_word[g]),
            .fwd_hit_i(fwd_hit[g]), .fwd_word_i(held[OTHER]),
            .ready_o(ready[g]), .mod_issue_o(mod_issue[g]), .tas_issue_o(tas_issue[g]),
            .rsv_valid_o(rsv_valid[g]), .rsv_addr_o(rsv_addr[g]), .held_o(held[g]),
            .we_o(we[g]), .waddr_o(waddr[g]), .wdata_o(mem_wdata[g]),
            .rsp_valid_o(rsp_valid[g]), .rsp_busy_o(rsp_busy[g]),
            .rsp_pass_o(rsp_pass[g]), .rsp_data_o(rsp_data[g])
        );
    end

    tas_conflict #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .SENTINEL(SENTINEL), .FLAG_WORD(FLAG_WORD)
    ) u_conflict (
        .mod_issue(mod_issue), .tas_issue(tas_issue), .addr(addr),
        .rd_word(rd_word), .rsv_valid(rsv_valid), .rsv_addr(rsv_addr),
        .busy(busy)
    );

    tas_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(waddr), .wdata(mem_wdata),
        .raddr(addr), .rdata(rd_word)
    );

    AST_RESERVATIONS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsv_valid[0] && rsv_valid[1] && rsv_addr[0] == rsv_addr[1])) else $error("word reserved twice"); // R8
    AST_NO_WRITE_INTO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid[0] && we[1]) |-> (waddr[1] != rsv_addr[0])) else $error("B wrote reserved word"); // R5
    AST_BUSY_IS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_busy[1] |-> rsp_valid[1]) else $error("busy without valid"); // R6
endmodule

// File: tb/tb_tas_dpram.sv
// Drives one stimulus into a default-mode and a sentinel-mode instance
// and checks both against arithmetic expectations.
module tb_tas_dpram;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam logic [DW-1:0] MARK = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_req = 1'b0, b_req = 1'b0;
    logic [1:0] a_op = '0, b_op = '0, a_test = '0, b_test = '0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0, a_cmp = '0, b_cmp = '0;

    logic n_a_ready, n_a_valid, n_a_busy, n_a_pass;
    logic n_b_ready, n_b_valid, n_b_busy, n_b_pass;
    logic s_a_ready, s_a_valid, s_a_busy, s_a_pass;
    logic s_b_ready, s_b_valid, s_b_busy, s_b_pass;
    logic [DW-1:0] n_a_data, n_b_data, s_a_data, s_b_data;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tas_dpram #(.DATA_W(DW), .ADDR_W(AW), .SENTINEL(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_op(a_op), .a_addr(a_addr), .a_wdata(a_wdata), .a_cmp(a_cmp), .a_test(a_test),
        .a_ready(n_a_ready), .a_rsp_valid(n_a_valid), .a_rsp_busy(n_a_busy), .a_rsp_pass(n_a_pass), .a_rsp_data(n_a_data),
        .b_req(b_req), .b_op(b_op), .b_addr(b_addr), .b_wdata(b_wdata), .b_cmp(b_cmp), .b_test(b_test),
        .b_ready(n_b_ready), .b_rsp_valid(n_b_valid), .b_rsp_busy(n_b_busy), .b_rsp_pass(n_b_pass), .b_rsp_data(n_b_data)
    );

    tas_dpram #(.DATA_W(DW), .ADDR_W(AW), .SENTINEL(1'b1), .FLAG_WORD(MARK)) dut_sen (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_op(a_op), .a_addr(a_addr), .a_wdata(a_wdata), .a_cmp(a_cmp), .a_test(a_test),
        .a_ready(s_a_ready), .a_rsp_valid(s_a_valid), .a_rsp_busy(s_a_busy), .a_rsp_pass(s_a_pass), .a_rsp_data(s_a_data),
        .b_req(b_req), .b_op(b_op), .b_addr(b_addr), .b_wdata(b_wdata), .b_cmp(b_cmp), .b_test(b_test),
        .b_ready(s_b_ready), .b_rsp_valid(s_b_valid), .b_rsp_busy(s_b_busy), .b_rsp_pass(s_b_pass), .b_rsp_data(s_b_data)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Port outputs by index: 0 = A, 1 = B; sen selects the sentinel instance.
    function automatic logic [DW+4-1:0] outs(int p, bit sen);
        if (!sen) return (p == 0) ? {n_a_ready, n_a_valid, n_a_busy, n_a_pass, n_a_data}
                                  : {n_b_ready, n_b_valid, n_b_busy, n_b_pass, n_b_data};
        return (p == 0) ? {s_a_ready, s_a_valid, s_a_busy, s_a_pass, s_a_data}
                        : {s_b_ready, s_b_valid, s_b_busy, s_b_pass, s_b_data};
    endfunction

    // Check ready, valid, busy, pass, data of port p on both instances.
    task automatic expect_port(string tag, int p, bit rdy, bit vld, bit bsy, bit pss, logic [DW-1:0] dat, bit chk_data);
        for (int s = 0; s < 2; s++) begin
            logic [DW+4-1:0] o = outs(p, s[0]);
            check({tag, s ? " sen ready" : " ready"}, o[DW+3], rdy);
            check({tag, s ? " sen valid" : " valid"}, o[DW+2], vld);
            check({tag, s ? " sen busy"  : " busy"},  o[DW+1], bsy);
            check({tag, s ? " sen pass"  : " pass"},  o[DW],   pss);
            if (chk_data) check({tag, s ? " sen data" : " data"}, o[DW-1:0], dat);
        end
    endtask

    task automatic drive(int p, logic [1:0] op, logic [AW-1:0] ad, logic [DW-1:0] wd, logic [DW-1:0] cm, logic [1:0] ts);
        if (p == 0) begin a_req = 1; a_op = op; a_addr = ad; a_wdata = wd; a_cmp = cm; a_test = ts; end
        else        begin b_req = 1; b_op = op; b_addr = ad; b_wdata = wd; b_cmp = cm; b_test = ts; end
    endtask

    task automatic release_ports();
        a_req = 0; b_req = 0; a_op = 0; b_op = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(int p, logic [AW-1:0] ad, logic [DW-1:0] d);
        drive(p, 2'b10, ad, d, '0, 2'b00); step(); release_ports();
        expect_port("R1 write ack", p, 1, 1, 0, 0, '0, 0);
    endtask

    task automatic rd(string tag, int p, logic [AW-1:0] ad, logic [DW-1:0] exp);
        drive(p, 2'b01, ad, '0, '0, 2'b00); step(); release_ports();
        expect_port(tag, p, 1, 1, 0, 0, exp, 1);
    endtask

    task automatic tas(string tag, int p, logic [AW-1:0] ad, logic [DW-1:0] v, logic [DW-1:0] cm,
                       logic [1:0] ts, logic [DW-1:0] old, bit pss);
        drive(p, 2'b11, ad, v, cm, ts); step(); release_ports();
        expect_port({tag, " R2 eval"}, p, 0, 0, 0, 0, '0, 0);
        step();
        expect_port(tag, p, 1, 1, 0, pss, old, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] olds [4];
        logic [DW-1:0] cmps [2];
        olds = '{8'd0, 8'd1, 8'd5, 8'd255};
        cmps = '{8'd5, 8'd0};
        repeat (3) step();
        // R13: reset state
        expect_port("R13 reset A", 0, 1, 0, 0, 0, '0, 0);
        expect_port("R13 reset B", 1, 1, 0, 0, 0, '0, 0);
        rst_n = 1'b1;
        step();
        for (int i = 0; i < 16; i++) rd("R13 cleared", i % 2, i[AW-1:0], '0);

        // R1: fill from alternating ports, read back from the opposite port
        for (int i = 0; i < 16; i++) wr(i % 2, i[AW-1:0], 8'(i * 17 + 3));
        for (int i = 0; i < 16; i++) rd("R1 readback", 1 - (i % 2), i[AW-1:0], 8'(i * 17 + 3));

        // R3 R4 R11: sweep of condition codes, prior words and operands
        for (int t = 0; t < 4; t++) begin
            for (int o = 0; o < 4; o++) begin
                for (int c = 0; c < 2; c++) begin
                    bit pss;
                    case (t)
                        0: pss = 1;
                        1: pss = (olds[o] == cmps[c]);
                        2: pss = (olds[o] == 0);
                        default: pss = (olds[o] != 0);
                    endcase
                    wr(0, 4'd2, olds[o]);
                    tas("R3 condition", 0, 4'd2, 8'h3C, cmps[c], t[1:0], olds[o], pss);
                    rd("R4 stored R11", 1, 4'd2, pss ? 8'h3C : olds[o]);
                end
            end
        end

        // R5 R10: B update during A's evaluate cycle is refused, then retried
        wr(0, 4'd3, 8'h10);
        drive(0, 2'b11, 4'd3, 8'h20, '0, 2'b00); step(); release_ports();
        drive(1, 2'b11, 4'd3, 8'h77, '0, 2'b00); step(); release_ports();
        expect_port("R5 A completes", 0, 1, 1, 0, 1, 8'h10, 1);
        expect_port("R5 B busy", 1, 1, 1, 1, 0, '0, 0);
        rd("R5 word untouched by B", 1, 4'd3, 8'h20);
        tas("R10 retry", 1, 4'd3, 8'h30, '0, 2'b00, 8'h20, 1);

        // R6: B write during A's evaluate cycle is dropped
        drive(0, 2'b11, 4'd3, 8'h40, '0, 2'b00); step(); release_ports();
        drive(1, 2'b10, 4'd3, 8'h99, '0, 2'b00); step(); release_ports();
        expect_port("R6 B write busy", 1, 1, 1, 1, 0, '0, 0);
        rd("R6 write dropped", 0, 4'd3, 8'h40);

        // R7: B read during A's evaluate cycle sees the prior word
        drive(0, 2'b11, 4'd3, 8'h50, 8'h40, 2'b01); step(); release_ports();
        drive(1, 2'b01, 4'd3, '0, '0, 2'b00); step(); release_ports();
        expect_port("R7 pre-update read", 1, 1, 1, 0, 0, 8'h40, 1);
        expect_port("R7 A result", 0, 1, 1, 0, 1, 8'h40, 1);
        rd("R7 after update", 1, 4'd3, 8'h50);

        // R8: same-cycle tie on one address, A proceeds and B is refused
        drive(0, 2'b11, 4'd5, 8'h01, '0, 2'b00);
        drive(1, 2'b11, 4'd5, 8'h02, '0, 2'b00); step(); release_ports();
        expect_port("R8 B busy", 1, 1, 1, 1, 0, '0, 0);
        expect_port("R8 A in eval", 0, 0, 0, 0, 0, '0, 0);
        step();
        expect_port("R8 A result", 0, 1, 1, 0, 1, 8'(5 * 17 + 3), 1);
        rd("R8 A value kept", 1, 4'd5, 8'h01);

        // R9: parallel updates to different words
        drive(0, 2'b11, 4'd6, 8'hA1, '0, 2'b00);
        drive(1, 2'b11, 4'd7, 8'hB2, '0, 2'b00); step(); release_ports();
        expect_port("R9 A eval", 0, 0, 0, 0, 0, '0, 0);
        expect_port("R9 B eval", 1, 0, 0, 0, 0, '0, 0);
        step();
        expect_port("R9 A result", 0, 1, 1, 0, 1, 8'(6 * 17 + 3), 1);
        expect_port("R9 B result", 1, 1, 1, 0, 1, 8'(7 * 17 + 3), 1);
        rd("R9 word A", 1, 4'd6, 8'hA1);
        rd("R9 word B", 0, 4'd7, 8'hB2);

        // R12: lock acquire, contend, release, reacquire
        wr(0, 4'd4, 8'h00);
        tas("R12 acquire", 0, 4'd4, 8'h01, '0, 2'b10, 8'h00, 1);
        tas("R12 contend", 1, 4'd4, 8'h01, '0, 2'b10, 8'h01, 0);
        wr(0, 4'd4, 8'h00);
        tas("R12 reacquire", 1, 4'd4, 8'h01, '0, 2'b10, 8'h00, 1);

        // R11: stored marker word, sentinel instance refuses, default passes
        wr(0, 4'd9, MARK);
        drive(1, 2'b11, 4'd9, 8'h11, '0, 2'b00); step(); release_ports();
        check("R11 sen busy", s_b_busy, 1);
        check("R11 sen valid", s_b_valid, 1);
        check("R11 default eval ready", n_b_ready, 0);
        step();
        check("R11 default pass", n_b_pass, 1);
        check("R11 default old", n_b_data, MARK);

        // R2: request during evaluate cycle is ignored
        wr(0, 4'd8, 8'h22);
        drive(0, 2'b11, 4'd8, 8'h33, '0, 2'b00); step();
        drive(0, 2'b10, 4'd8, 8'hEE, '0, 2'b00); step(); release_ports();
        expect_port("R2 result", 0, 1, 1, 0, 1, 8'h22, 1);
        step();
        check("R2 ignored no rsp", n_a_valid, 0);
        rd("R2 ignored write", 1, 4'd8, 8'h33);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule